// File: doc/BRIEF.md
# UART Fractional Baud Divider

This block turns a system clock into the timing strobes a UART needs. A 16-bit integer divisor sets the base period of the oversampling strobe, and a 4-bit fraction lengthens a fixed share of those periods by one clock. The average period therefore lies between two integer steps, at divisor + fraction/16. One divider output serves the transmitter and the receiver. The receiver takes the 16x oversampling strobe. The transmitter takes a bit strobe that fires on every sixteenth oversampling strobe.

The host can write the divisor and the fraction at any time. An autobaud loader can also overwrite the fraction with a value it has measured. Both kinds of write are plain one-cycle strobes with data; they have no back-pressure. A write never cuts short the period that is already running. The new value is sampled when the next period is loaded. While the fraction is zero, which is its value after reset, the strobes come at exactly the spacing of a plain integer divider.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, both strobes are low. After reset the divisor is RST_DIV (default 16) and the fraction is 0. The first oversampling strobe appears on the first clock edge after reset is released.
- R2: With the fraction at 0, every interval between oversampling strobes equals the integer divisor exactly.
- R3: With fraction F (0..15) and divisor D, any 16 consecutive intervals are each D or D+1 clocks long, exactly F of them are D+1, and their sum is 16*D+F.
- R4: A host divisor write (host_div_we high for one cycle) loads host_div. A host fraction write (host_frac_we) loads host_frac.
- R5: An autobaud write (abd_we) loads abd_frac into the fraction. If it coincides with a host fraction write, the autobaud value is kept and the host value has no effect.
- R6: A divisor value of 0 behaves as 1, so strobes never stop.
- R7: A write takes effect only at a period boundary. The interval in progress when the write lands keeps the length it was loaded with.
- R8: bit_tick is high only together with os_tick, on every sixteenth os_tick counted from reset. The first one is on the sixteenth os_tick.
- R9: os_tick is a one-cycle pulse per period, and no interval exceeds 2^16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_div_we | input | 1 | Host strobe to load the integer divisor |
| host_div | input | 16 | Host integer divisor value |
| host_frac_we | input | 1 | Host strobe to load the fraction |
| host_frac | input | 4 | Host fraction value |
| abd_we | input | 1 | Autobaud strobe to load the fraction |
| abd_frac | input | 4 | Autobaud measured fraction |
| os_tick | output | 1 | 16x oversampling strobe for the receiver |
| bit_tick | output | 1 | Bit strobe for the transmitter |

## Verification
The assertions check on every cycle that:
- each register write lands in the stored divisor or fraction, with autobaud winning a collision;
- bit strobes line up with every sixteenth oversampling strobe;
- the time between strobes stays bounded.

The bench scenarios show the timing itself:
- the exact integer spacing when the fraction is zero;
- the share of stretched periods for a given fraction;
- divisor zero behaving as one;
- a mid-period write leaving the running interval untouched.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  localparam int unsigned FBD_DIV_W   = 16;
  localparam int unsigned FBD_FRAC_W  = 4;
  localparam int unsigned FBD_OS_RATE = 16;

  typedef enum logic [1:0] {
    FSRC_NONE = 2'd0,
    FSRC_HOST = 2'd1,
    FSRC_ABD  = 2'd2
  } frac_src_e;
endpackage

// File: rtl/fbd_cfg_regs.sv
module fbd_cfg_regs
  import fbd_pkg::*;
#(
  parameter int unsigned DIV_W   = FBD_DIV_W,
  parameter int unsigned FRAC_W  = FBD_FRAC_W,
  parameter int unsigned RST_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_div_we,
  input  logic [DIV_W-1:0]  host_div,
  input  logic              host_frac_we,
  input  logic [FRAC_W-1:0] host_frac,
  input  logic              abd_we,
  input  logic [FRAC_W-1:0] abd_frac,
  output logic [DIV_W-1:0]  div_q,
  output logic [FRAC_W-1:0] frac_q
);
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(RST_DIV);

  frac_src_e src;

  // Autobaud has priority over the host on the fraction field.
  always_comb begin
    if (abd_we)            src = FSRC_ABD;
    else if (host_frac_we) src = FSRC_HOST;
    else                   src = FSRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_RESET;
    end else if (host_div_we) begin
      div_q <= host_div;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frac_q <= '0;
    end else begin
      unique case (src)
        FSRC_ABD:  frac_q <= abd_frac;
        FSRC_HOST: frac_q <= host_frac;
        default:   frac_q <= frac_q;
      endcase
    end
  end
endmodule

// File: rtl/fbd_period_gen.sv
module fbd_period_gen
  import fbd_pkg::*;
#(
  parameter int unsigned DIV_W  = FBD_DIV_W,
  parameter int unsigned FRAC_W = FBD_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic [FRAC_W-1:0] frac,
  output logic              bound,
  output logic              os_tick
);
  logic [DIV_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   acc_sum;
  logic [DIV_W-1:0]  eff_div;
  logic [DIV_W-1:0]  cnt_load;
  logic              stretch;

  // A divisor of zero is run as one so the strobe never stalls.
  assign eff_div  = (div == '0) ? DIV_W'(1) : div;
  assign acc_sum  = {1'b0, acc} + {1'b0, frac};
  assign stretch  = acc_sum[FRAC_W];
  // The reload value is eff_div-1, plus one when the accumulator carries.
  assign cnt_load = (eff_div - DIV_W'(1)) + DIV_W'(stretch);
  assign bound    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      acc     <= '0;
      os_tick <= 1'b0;
    end else begin
      os_tick <= bound;
      if (bound) begin
        cnt <= cnt_load;
        acc <= acc_sum[FRAC_W-1:0];
      end else begin
        cnt <= cnt - DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/fbd_bit_div.sv
module fbd_bit_div
  import fbd_pkg::*;
#(
  parameter int unsigned RATE = FBD_OS_RATE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bound,
  output logic bit_tick
);
  localparam int unsigned CW = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATE - 1);

  logic [CW-1:0] os_cnt;

  generate
    if (RATE == 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          os_cnt   <= '0;
          bit_tick <= 1'b0;
        end else begin
          os_cnt   <= '0;
          bit_tick <= bound;
        end
      end
    end else begin : g_count
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          os_cnt   <= '0;
          bit_tick <= 1'b0;
        end else begin
          bit_tick <= bound && (os_cnt == LAST);
          if (bound) begin
            os_cnt <= (os_cnt == LAST) ? '0 : os_cnt + CW'(1);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbd_pkg::*;
#(
  parameter int unsigned DIV_W   = FBD_DIV_W,
  parameter int unsigned FRAC_W  = FBD_FRAC_W,
  parameter int unsigned OS_RATE = FBD_OS_RATE,
  parameter int unsigned RST_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_div_we,
  input  logic [DIV_W-1:0]  host_div,
  input  logic              host_frac_we,
  input  logic [FRAC_W-1:0] host_frac,
  input  logic              abd_we,
  input  logic [FRAC_W-1:0] abd_frac,
  output logic              os_tick,
  output logic              bit_tick
);
  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  logic              bound;

  fbd_cfg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .RST_DIV(RST_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_div_we(host_div_we), .host_div(host_div),
    .host_frac_we(host_frac_we), .host_frac(host_frac),
    .abd_we(abd_we), .abd_frac(abd_frac),
    .div_q(div_q), .frac_q(frac_q)
  );

  fbd_period_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_period (
    .clk(clk), .rst_n(rst_n),
    .div(div_q), .frac(frac_q),
    .bound(bound), .os_tick(os_tick)
  );

  fbd_bit_div #(.RATE(OS_RATE)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .bound(bound), .bit_tick(bit_tick)
  );
endmodule

// File: rtl/fbd_checker.sv
module fbd_checker #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned FRAC_W  = 4,
  parameter int unsigned OS_RATE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_div_we,
  input logic [DIV_W-1:0]  host_div,
  input logic              host_frac_we,
  input logic [FRAC_W-1:0] host_frac,
  input logic              abd_we,
  input logic [FRAC_W-1:0] abd_frac,
  input logic [DIV_W-1:0]  div_q,
  input logic [FRAC_W-1:0] frac_q,
  input logic              os_tick,
  input logic              bit_tick
);
  localparam int unsigned GW = DIV_W + 2;
  localparam logic [GW-1:0] GAP_MAX = GW'(1) << DIV_W;

  logic [GW-1:0] gap;
  int unsigned   os_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap     <= '0;
      os_seen <= 0;
    end else begin
      gap <= os_tick ? GW'(1) : ((gap == GAP_MAX + GW'(1)) ? gap : gap + GW'(1));
      if (bit_tick)     os_seen <= 0;
      else if (os_tick) os_seen <= os_seen + 1;
    end
  end

  p_div_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_div_we |=> div_q == $past(host_div));

  p_host_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_frac_we && !abd_we) |=> frac_q == $past(host_frac));

  p_abd_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abd_we |=> frac_q == $past(abd_frac));

  p_bit_with_os_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  p_bit_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> (bit_tick == (os_seen == OS_RATE - 1)));

  p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= GAP_MAX);
endmodule

bind frac_baud_gen fbd_checker #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .OS_RATE(OS_RATE)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_div_we(host_div_we), .host_div(host_div),
  .host_frac_we(host_frac_we), .host_frac(host_frac),
  .abd_we(abd_we), .abd_frac(abd_frac),
  .div_q(div_q), .frac_q(frac_q),
  .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_div_we = 1'b0;
  logic [15:0] host_div = '0;
  logic        host_frac_we = 1'b0;
  logic [3:0]  host_frac = '0;
  logic        abd_we = 1'b0;
  logic [3:0]  abd_frac = '0;
  logic        os_tick;
  logic        bit_tick;

  int n_chk = 0;
  int n_err = 0;
  int orphan_bits = 0;

  always #(CLK_P/2) clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n),
    .host_div_we(host_div_we), .host_div(host_div),
    .host_frac_we(host_frac_we), .host_frac(host_frac),
    .abd_we(abd_we), .abd_frac(abd_frac),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  // R8: bit_tick must never appear without os_tick
  always @(negedge clk) if (rst_n && bit_tick && !os_tick) orphan_bits++;

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int exp_total(input int d, input int f);
    return 16 * eff(d) + f;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!os_tick && gap < 70000);
  endtask

  task automatic wr_div(input int v);
    @(negedge clk);
    host_div_we = 1'b1; host_div = 16'(v);
    @(negedge clk);
    host_div_we = 1'b0;
  endtask

  task automatic wr_frac(input int v);
    @(negedge clk);
    host_frac_we = 1'b1; host_frac = 4'(v);
    @(negedge clk);
    host_frac_we = 1'b0;
  endtask

  // Settle two periods, then measure 16 intervals against the expected pattern.
  task automatic measure(input int d, input int f, input string req);
    int g, total, nlong, bad;
    next_tick(g);
    next_tick(g);
    total = 0; nlong = 0; bad = 0;
    for (int i = 0; i < 16; i++) begin
      next_tick(g);
      total += g;
      if (g == eff(d) + 1) nlong++;
      else if (g != eff(d)) bad++;
    end
    chk(total == exp_total(d, f), {req, " sum of 16 intervals"}, total, exp_total(d, f));
    chk(nlong == f, {req, " count of stretched intervals"}, nlong, f);
    chk(bad == 0, {req, " intervals outside D..D+1"}, bad, 0);
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int g, cnt, d, f, fh;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: strobes low during reset
    chk(os_tick == 1'b0 && bit_tick == 1'b0, "R1 strobes low in reset", {os_tick, bit_tick}, 0);
    rst_n = 1'b1;
    next_tick(g);
    chk(g == 1, "R1 first os_tick one edge after release", g, 1);
    // R1/R8: reset divisor 16, first bit strobe on the 16th os_tick
    cnt = 1;
    while (!bit_tick && cnt < 40) begin
      next_tick(g);
      cnt++;
      chk(g == 16, "R1 reset divisor interval", g, 16);
    end
    chk(cnt == 16, "R8 first bit_tick on 16th os_tick", cnt, 16);
    cnt = 0;
    do begin next_tick(g); cnt++; end while (!bit_tick && cnt < 40);
    chk(cnt == 16, "R8 bit_tick spacing", cnt, 16);

    // R2/R4: integer division, fraction zero
    wr_div(5);   measure(5, 0, "R2 div5");
    wr_div(23);  measure(23, 0, "R2 div23");
    // R3/R4: fractional patterns
    wr_frac(8);  measure(23, 8, "R3 div23 frac8");
    wr_div(3); wr_frac(15); measure(3, 15, "R3 div3 frac15");
    wr_frac(1);  measure(3, 1, "R3 div3 frac1");

    // R5: collision, autobaud wins
    @(negedge clk);
    host_frac_we = 1'b1; host_frac = 4'd2; abd_we = 1'b1; abd_frac = 4'd11;
    @(negedge clk);
    host_frac_we = 1'b0; abd_we = 1'b0;
    measure(3, 11, "R5 autobaud over host");
    @(negedge clk);
    abd_we = 1'b1; abd_frac = 4'd6;
    @(negedge clk);
    abd_we = 1'b0;
    measure(3, 6, "R5 autobaud alone");

    // R6: divisor zero behaves as one
    wr_frac(0); wr_div(0); measure(0, 0, "R6 div0");
    wr_frac(5); measure(0, 5, "R6 div0 frac5");

    // R7: mid-period write keeps running interval
    wr_frac(0); wr_div(40);
    next_tick(g); next_tick(g);
    g = 0;
    repeat (4) begin @(negedge clk); g++; end
    host_div_we = 1'b1; host_div = 16'd7;
    @(negedge clk); g++;
    host_div_we = 1'b0;
    while (!os_tick && g < 100) begin @(negedge clk); g++; end
    chk(g == 40, "R7 interval in progress kept", g, 40);
    next_tick(g);
    chk(g == 7, "R7 new divisor at next boundary", g, 7);

    // R3: random configurations
    for (int i = 0; i < 6; i++) begin
      d = int'($urandom_range(60, 1));
      f = int'($urandom_range(15, 0));
      fh = int'($urandom_range(15, 0));
      wr_div(d);
      if (i % 2 == 0) begin
        wr_frac(f);
      end else begin
        @(negedge clk);
        host_frac_we = 1'b1; host_frac = 4'(fh); abd_we = 1'b1; abd_frac = 4'(f);
        @(negedge clk);
        host_frac_we = 1'b0; abd_we = 1'b0;
      end
      measure(d, f, "R3 random");
    end

    chk(orphan_bits == 0, "R8 bit_tick only with os_tick", orphan_bits, 0);
    // R9: single-cycle pulse
    wr_div(4); next_tick(g); @(negedge clk);
    chk(os_tick == 1'b0, "R9 os_tick one cycle wide", os_tick, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule